// File: doc/BRIEF.md
# Standby Wakeup and Release Controller

This block parks a small processor core in a clock-stopped standby state and brings it back out. A one-cycle stop strobe from the core moves the block into standby and drops the oscillator enable. While parked, the block watches two non-maskable interrupt lines, each with its own mask bit, a bank of maskable requests, each with a wake enable and a priority level, and a set of reset sources. The first qualifying event turns the oscillator enable back on at once. A programmable stabilization interval then runs down to zero, and only after that does the block issue a one-cycle resume pulse.

The resume pulse carries a 2-bit action code that tells the core what to do next: continue at the next instruction, branch to an interrupt handler, or run the reset sequence. It also names the source. Any unmasked event ends standby. Whether a maskable event is actually taken depends on the global interrupt-enable flag, and, when standby was entered from inside a handler, on the request's priority compared with the level in service. Maskable requests seen while parked are latched as pending and stay set until the core clears them.

Top module: `sbw_standby_ctrl`

## Requirements
- R1: A high `stop_req` sampled while running puts the block in standby from the next cycle: `in_standby` goes high and `osc_en` goes low. While in standby or stabilizing, `stop_req` is ignored.
- R2: A maskable request whose `irq_en` bit is 0, or a non-maskable line whose `nmi_mask` bit is 1, has no effect: standby continues and `osc_en` stays low.
- R3: In standby, a maskable request with its enable bit set ends standby whatever its priority. `osc_en` is high in the same cycle the event is present, and `stab_busy` rises on the next cycle.
- R4: On the wake edge the interval counter loads `stab_len` = L. `stab_busy` is then high for L+1 cycles. `resume_valid` is a one-cycle pulse in the cycle after, i.e. L+2 cycles after the event was first presented. The block is then running again.
- R5: A non-maskable wake resumes with code 2'b01 (vector) and `resume_nmi`=1, whatever `gie` and `in_service` are. Line 0 has precedence over line 1, and `resume_id` gives the line number.
- R6: A maskable wake with `gie`=0 resumes with code 2'b00 (next instruction).
- R7: With `gie`=1 and `in_service`=1, a maskable wake whose priority is not above `isr_prio` resumes with code 2'b00. Its bit stays set in `pend`.
- R8: With `gie`=1, a maskable wake is acknowledged with code 2'b01 when `in_service`=0 or its priority is strictly above `isr_prio`. `resume_id` names the request.
- R9: Any `rst_src` bit high in standby wakes the block with code 2'b10 (reset). This takes precedence over every interrupt presented in the same cycle.
- R10: While the block is in standby or stabilizing, and on the stop edge itself, every enabled request sets its `pend` bit. A `pend_clr` bit clears that bit unless it is being set in the same cycle.
- R11: Among several enabled maskable requests, the winner has the numerically largest `irq_prio` field (bits [i*PW +: PW]). On a tie the lowest index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stop_req | input | 1 | Enter-standby strobe from the core |
| nmi_req | input | 2 | Non-maskable interrupt lines |
| nmi_mask | input | 2 | 1 = line cannot wake |
| irq_req | input | N_IRQ | Maskable interrupt requests |
| irq_en | input | N_IRQ | 1 = request may wake and latch |
| irq_prio | input | N_IRQ*PW | Packed priority per request, larger = more urgent |
| in_service | input | 1 | Standby entered from inside a handler |
| isr_prio | input | PW | Priority of the handler in service |
| gie | input | 1 | Global interrupt enable |
| rst_src | input | N_RST | Reset sources |
| stab_len | input | CW | Stabilization interval in cycles |
| pend_clr | input | N_IRQ | Per-request pending clear |
| osc_en | output | 1 | Oscillator enable |
| in_standby | output | 1 | Standby or stabilization in progress |
| stab_busy | output | 1 | Stabilization interval running |
| resume_valid | output | 1 | One-cycle resume pulse |
| resume_code | output | 2 | 00 next, 01 vector, 10 reset |
| resume_nmi | output | 1 | Resume caused by a non-maskable line |
| resume_id | output | IDW | Winning request or line index |
| pend | output | N_IRQ | Latched pending requests |

## Verification
`osc_en` is combinational on the wake inputs, so it is due in the same cycle as the event. `in_standby` and `stab_busy` follow one edge later. `resume_valid`, together with its code, source and id, is due exactly L+2 cycles after the event is presented. The bench drives inputs a quarter period after the rising edge and compares every output against its model at the falling edge. Each episode also counts cycles up to the resume pulse and checks that count against L+2.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'b00,
        ST_STBY = 2'b01,
        ST_STAB = 2'b10
    } sbw_state_e;

    typedef enum logic [1:0] {
        RES_NEXT   = 2'b00,
        RES_VECTOR = 2'b01,
        RES_RESET  = 2'b10
    } sbw_resume_e;

endpackage

// File: rtl/sbw_wake_arb.sv
module sbw_wake_arb
    import sbw_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int PW    = 3,
    parameter int IDW   = 3
) (
    input  logic [1:0]        nmi_req,
    input  logic [1:0]        nmi_mask,
    input  logic [N_IRQ-1:0]  irq_req,
    input  logic [N_IRQ-1:0]  irq_en,
    input  logic [N_IRQ*PW-1:0] irq_prio,
    input  logic              in_service,
    input  logic [PW-1:0]     isr_prio,
    input  logic              gie,
    input  logic              rst_any,
    output logic              wake,
    output sbw_resume_e       code,
    output logic              is_nmi,
    output logic [IDW-1:0]    id,
    output logic [N_IRQ-1:0]  live
);

    logic [1:0]     nmi_live;
    logic           found;
    logic [PW-1:0]  best_p;
    logic [IDW-1:0] best_i;
    logic           acked;

    assign live     = irq_req & irq_en;
    assign nmi_live = nmi_req & ~nmi_mask;

    // highest priority field wins; strict compare keeps the lowest index on ties
    always_comb begin
        found  = 1'b0;
        best_p = '0;
        best_i = '0;
        for (int i = 0; i < N_IRQ; i++) begin
            if (live[i] && (!found || irq_prio[i*PW +: PW] > best_p)) begin
                found  = 1'b1;
                best_p = irq_prio[i*PW +: PW];
                best_i = IDW'(i);
            end
        end
    end

    assign acked = gie && (!in_service || (best_p > isr_prio));

    always_comb begin
        wake   = 1'b0;
        code   = RES_NEXT;
        is_nmi = 1'b0;
        id     = '0;
        if (rst_any) begin
            wake = 1'b1;
            code = RES_RESET;
        end else if (nmi_live[0]) begin
            wake   = 1'b1;
            code   = RES_VECTOR;
            is_nmi = 1'b1;
        end else if (nmi_live[1]) begin
            wake   = 1'b1;
            code   = RES_VECTOR;
            is_nmi = 1'b1;
            id     = IDW'(1);
        end else if (found) begin
            wake = 1'b1;
            code = acked ? RES_VECTOR : RES_NEXT;
            id   = best_i;
        end
    end

endmodule

// File: rtl/sbw_stab_timer.sv
module sbw_stab_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          zero
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sbw_standby_ctrl.sv
module sbw_standby_ctrl
    import sbw_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int PW    = 3,
    parameter int CW    = 16,
    parameter int N_RST = 2,
    localparam int IDW  = (N_IRQ > 2) ? $clog2(N_IRQ) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stop_req,
    input  logic [1:0]          nmi_req,
    input  logic [1:0]          nmi_mask,
    input  logic [N_IRQ-1:0]    irq_req,
    input  logic [N_IRQ-1:0]    irq_en,
    input  logic [N_IRQ*PW-1:0] irq_prio,
    input  logic                in_service,
    input  logic [PW-1:0]       isr_prio,
    input  logic                gie,
    input  logic [N_RST-1:0]    rst_src,
    input  logic [CW-1:0]       stab_len,
    input  logic [N_IRQ-1:0]    pend_clr,
    output logic                osc_en,
    output logic                in_standby,
    output logic                stab_busy,
    output logic                resume_valid,
    output logic [1:0]          resume_code,
    output logic                resume_nmi,
    output logic [IDW-1:0]      resume_id,
    output logic [N_IRQ-1:0]    pend
);

    typedef struct packed {
        sbw_state_e        state;
        sbw_resume_e       code;
        logic              is_nmi;
        logic [IDW-1:0]    id;
        logic              rv;
        logic [N_IRQ-1:0]  pend;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    logic              wake_any;
    sbw_resume_e       arb_code;
    logic              arb_nmi;
    logic [IDW-1:0]    arb_id;
    logic [N_IRQ-1:0]  live;
    logic              parked;
    logic              wake_take;
    logic              stab_zero;
    logic              capture;

    sbw_wake_arb #(
        .N_IRQ (N_IRQ),
        .PW    (PW),
        .IDW   (IDW)
    ) u_arb (
        .nmi_req    (nmi_req),
        .nmi_mask   (nmi_mask),
        .irq_req    (irq_req),
        .irq_en     (irq_en),
        .irq_prio   (irq_prio),
        .in_service (in_service),
        .isr_prio   (isr_prio),
        .gie        (gie),
        .rst_any    (|rst_src),
        .wake       (wake_any),
        .code       (arb_code),
        .is_nmi     (arb_nmi),
        .id         (arb_id),
        .live       (live)
    );

    assign parked    = (ctl_q.state == ST_STBY);
    assign wake_take = parked && wake_any;

    sbw_stab_timer #(
        .CW (CW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wake_take),
        .load_val (stab_len),
        .run      (ctl_q.state == ST_STAB),
        .zero     (stab_zero)
    );

    // pending requests are captured on the stop edge and throughout standby
    assign capture = (ctl_q.state != ST_RUN) || stop_req;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.rv   = 1'b0;
        ctl_d.pend = (ctl_q.pend & ~pend_clr) | (capture ? live : '0);
        unique case (ctl_q.state)
            ST_RUN: begin
                if (stop_req) begin
                    ctl_d.state = ST_STBY;
                end
            end
            ST_STBY: begin
                if (wake_any) begin
                    ctl_d.state  = ST_STAB;
                    ctl_d.code   = arb_code;
                    ctl_d.is_nmi = arb_nmi;
                    ctl_d.id     = arb_id;
                end
            end
            ST_STAB: begin
                if (stab_zero) begin
                    ctl_d.state = ST_RUN;
                    ctl_d.rv    = 1'b1;
                end
            end
            default: ctl_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_RUN, code: RES_NEXT, is_nmi: 1'b0,
                       id: '0, rv: 1'b0, pend: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign osc_en       = !parked || wake_any;
    assign in_standby   = (ctl_q.state != ST_RUN);
    assign stab_busy    = (ctl_q.state == ST_STAB);
    assign resume_valid = ctl_q.rv;
    assign resume_code  = ctl_q.code;
    assign resume_nmi   = ctl_q.is_nmi;
    assign resume_id    = ctl_q.id;
    assign pend         = ctl_q.pend;

endmodule

// File: rtl/sbw_standby_chk.sv
module sbw_standby_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stop_req,
    input logic       wake_any,
    input logic       osc_en,
    input logic       in_standby,
    input logic       stab_busy,
    input logic       resume_valid,
    input logic [1:0] resume_code,
    input logic       resume_nmi
);

    // R1: a stop strobe while running lands in standby on the next cycle
    p_stop_enters_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !in_standby) |=> (in_standby && !stab_busy));

    // R2: parked with no qualifying event keeps the oscillator off
    p_osc_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_standby && !stab_busy && !wake_any) |-> !osc_en);

    // R4: a resume pulse comes only out of stabilization and lasts one cycle
    p_after_stab_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resume_valid) |-> $past(stab_busy));

    p_one_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        resume_valid |=> !resume_valid);

    // R5: non-maskable resumes always vector
    p_nmi_vectors_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_valid && resume_nmi) |-> (resume_code == 2'b01));

    // R9: only the three defined action codes appear
    p_code_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        resume_valid |-> (resume_code != 2'b11));

    // R3: stabilization keeps the oscillator running
    p_osc_on_stab_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stab_busy |-> osc_en);

endmodule

bind sbw_standby_ctrl sbw_standby_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .stop_req     (stop_req),
    .wake_any     (wake_any),
    .osc_en       (osc_en),
    .in_standby   (in_standby),
    .stab_busy    (stab_busy),
    .resume_valid (resume_valid),
    .resume_code  (resume_code),
    .resume_nmi   (resume_nmi)
);

// File: tb/sim_sbw_standby_ctrl.sv
`timescale 1ns/1ps
module sim_sbw_standby_ctrl;

    localparam int N  = 8;
    localparam int PW = 3;
    localparam int CW = 16;
    localparam int NR = 2;
    localparam int IDW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 1'b0;
    logic [1:0] nmi_req = '0, nmi_mask = '0;
    logic [N-1:0] irq_req = '0, irq_en = '0, pend_clr = '0;
    logic [N*PW-1:0] irq_prio = '0;
    logic in_service = 1'b0;
    logic [PW-1:0] isr_prio = '0;
    logic gie = 1'b0;
    logic [NR-1:0] rst_src = '0;
    logic [CW-1:0] stab_len = 16'd4;

    logic osc_en, in_standby, stab_busy, resume_valid, resume_nmi;
    logic [1:0] resume_code;
    logic [IDW-1:0] resume_id;
    logic [N-1:0] pend;

    int n_chk = 0;
    int n_fail = 0;
    string tag = "R0";

    always #10 clk = ~clk;

    sbw_standby_ctrl #(.N_IRQ(N), .PW(PW), .CW(CW), .N_RST(NR)) u0 (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .nmi_req(nmi_req),
        .nmi_mask(nmi_mask), .irq_req(irq_req), .irq_en(irq_en),
        .irq_prio(irq_prio), .in_service(in_service), .isr_prio(isr_prio),
        .gie(gie), .rst_src(rst_src), .stab_len(stab_len), .pend_clr(pend_clr),
        .osc_en(osc_en), .in_standby(in_standby), .stab_busy(stab_busy),
        .resume_valid(resume_valid), .resume_code(resume_code),
        .resume_nmi(resume_nmi), .resume_id(resume_id), .pend(pend)
    );

    // ---------------- reference model ----------------
    int m_state = 0;          // 0 running, 1 parked, 2 stabilizing
    int m_cnt = 0;
    int m_code = 0, m_nmi = 0, m_id = 0;
    bit m_rv = 1'b0;
    logic [N-1:0] m_pend = '0;

    function automatic bit ref_wake(output int code, output int nmi, output int id);
        int bp;
        int bi;
        code = 0; nmi = 0; id = 0;
        if (rst_src != 0) begin code = 2; return 1'b1; end
        if (nmi_req[0] && !nmi_mask[0]) begin code = 1; nmi = 1; return 1'b1; end
        if (nmi_req[1] && !nmi_mask[1]) begin code = 1; nmi = 1; id = 1; return 1'b1; end
        bp = -1; bi = -1;
        for (int i = 0; i < N; i++)
            if (irq_req[i] && irq_en[i] && int'(irq_prio[i*PW +: PW]) > bp) begin
                bp = int'(irq_prio[i*PW +: PW]); bi = i;
            end
        if (bi < 0) return 1'b0;
        id = bi;
        code = (gie && (!in_service || bp > int'(isr_prio))) ? 1 : 0;
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        int c, n, d;
        bit w;
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_rv = 0; m_pend = '0;
            m_code = 0; m_nmi = 0; m_id = 0;
        end else begin
            w = ref_wake(c, n, d);
            m_rv = 1'b0;
            if (m_state != 0 || stop_req)
                m_pend = (m_pend & ~pend_clr) | (irq_req & irq_en);
            else
                m_pend = m_pend & ~pend_clr;
            if (m_state == 0) begin
                if (stop_req) m_state = 1;
            end else if (m_state == 1) begin
                if (w) begin
                    m_state = 2; m_cnt = int'(stab_len);
                    m_code = c; m_nmi = n; m_id = d;
                end
            end else begin
                if (m_cnt == 0) begin m_state = 0; m_rv = 1'b1; end
                else m_cnt--;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // per-cycle comparison, sampled on the falling edge
    always @(negedge clk) begin
        int c, n, d;
        bit w;
        if (rst_n) begin
            w = ref_wake(c, n, d);
            chk(tag, "osc_en", int'(osc_en), int'(m_state != 1 || w));
            chk(tag, "in_standby", int'(in_standby), int'(m_state != 0));
            chk(tag, "stab_busy", int'(stab_busy), int'(m_state == 2));
            chk(tag, "resume_valid", int'(resume_valid), int'(m_rv));
            chk(tag, "pend", int'(pend), int'(m_pend));
            if (m_rv) begin
                chk(tag, "resume_code", int'(resume_code), m_code);
                chk(tag, "resume_nmi", int'(resume_nmi), m_nmi);
                chk(tag, "resume_id", int'(resume_id), m_id);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(posedge clk); #5;
    endtask

    task automatic clear_inputs();
        nmi_req = '0; nmi_mask = '0; irq_req = '0; irq_en = '0;
        rst_src = '0; in_service = 1'b0; isr_prio = '0; gie = 1'b0;
        pend_clr = '1;
        step();
        pend_clr = '0;
    endtask

    task automatic set_prio(input int i, input int p);
        irq_prio[i*PW +: PW] = PW'(p);
    endtask

    task automatic park();
        stop_req = 1'b1; step(); stop_req = 1'b0; step();
    endtask

    // inputs already applied in the current drive slot; wait for the resume
    task automatic await_resume(input string req, input int len,
                                input int e_code, input int e_nmi, input int e_id);
        int k;
        k = -1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (resume_valid) begin k = i; break; end
        end
        chk(req, "cycles to resume", k, len + 2);
        chk(req, "code", int'(resume_code), e_code);
        chk(req, "nmi", int'(resume_nmi), e_nmi);
        chk(req, "id", int'(resume_id), e_id);
        @(posedge clk); #5;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) set_prio(i, i % 4);
        repeat (3) step();
        tag = "R0";
        chk("R0", "reset osc_en", int'(osc_en), 1);
        chk("R0", "reset in_standby", int'(in_standby), 0);
        chk("R0", "reset resume_valid", int'(resume_valid), 0);
        rst_n = 1'b1;
        step();

        // R1: entering standby
        tag = "R1";
        park();
        @(negedge clk);
        chk("R1", "osc_en after stop", int'(osc_en), 0);
        chk("R1", "in_standby after stop", int'(in_standby), 1);
        step();
        stop_req = 1'b1; step(); stop_req = 1'b0;   // ignored while parked

        // R2: masked sources do nothing
        tag = "R2";
        irq_req[2] = 1'b1; irq_en[2] = 1'b0; nmi_req = 2'b11; nmi_mask = 2'b11;
        repeat (6) step();
        @(negedge clk);
        chk("R2", "osc_en with masked sources", int'(osc_en), 0);
        chk("R2", "still parked", int'(in_standby), 1);
        step();

        // R3 R8: low-priority enabled request, not in a handler, gie set
        tag = "R8";
        nmi_req = '0; nmi_mask = '0; gie = 1'b1; set_prio(2, 0); irq_en[2] = 1'b1;
        #1;
        chk("R3", "osc_en same cycle as wake", int'(osc_en), 1);
        await_resume("R8", 4, 1, 0, 2);
        clear_inputs();

        // R6: gie low -> next instruction
        tag = "R6";
        park();
        irq_req[5] = 1'b1; irq_en[5] = 1'b1; gie = 1'b0;
        await_resume("R6", 4, 0, 0, 5);
        clear_inputs();

        // R7 R10: in handler, lower priority -> next, stays pending
        tag = "R7";
        stab_len = 16'd2;
        park();
        set_prio(3, 3);
        irq_req[3] = 1'b1; irq_en[3] = 1'b1; gie = 1'b1; in_service = 1'b1; isr_prio = 3'd5;
        await_resume("R7", 2, 0, 0, 3);
        irq_req = '0;
        step();
        @(negedge clk);
        chk("R10", "pend held after resume", int'(pend[3]), 1);
        step();
        pend_clr[3] = 1'b1; step(); pend_clr = '0;
        @(negedge clk);
        chk("R10", "pend cleared", int'(pend[3]), 0);
        clear_inputs();

        // R8: in handler, higher priority -> vector
        tag = "R8";
        park();
        set_prio(6, 6);
        irq_req[6] = 1'b1; irq_en[6] = 1'b1; gie = 1'b1; in_service = 1'b1; isr_prio = 3'd5;
        await_resume("R8", 2, 1, 0, 6);
        clear_inputs();

        // R5: NMI with interrupts disabled in a high-priority handler
        tag = "R5";
        park();
        nmi_req = 2'b10; gie = 1'b0; in_service = 1'b1; isr_prio = 3'd7;
        irq_req[1] = 1'b1; irq_en[1] = 1'b1;
        await_resume("R5", 2, 1, 1, 1);
        clear_inputs();
        park();
        nmi_req = 2'b11;
        await_resume("R5", 2, 1, 1, 0);
        clear_inputs();

        // R11: equal priorities -> lowest index
        tag = "R11";
        park();
        set_prio(4, 7); set_prio(7, 7); set_prio(0, 2);
        irq_req = 8'b1001_0001; irq_en = 8'b1001_0001; gie = 1'b1;
        await_resume("R11", 2, 1, 0, 4);
        clear_inputs();

        // R9: reset source beats NMI and maskable
        tag = "R9";
        stab_len = 16'd3;
        park();
        rst_src = 2'b10; nmi_req = 2'b01; irq_req[4] = 1'b1; irq_en[4] = 1'b1; gie = 1'b1;
        await_resume("R9", 3, 2, 0, 0);
        clear_inputs();

        // R4: zero-length stabilization
        tag = "R4";
        stab_len = 16'd0;
        park();
        irq_req[0] = 1'b1; irq_en[0] = 1'b1;
        await_resume("R4", 0, 0, 0, 0);
        clear_inputs();
        repeat (3) step();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule